// File: doc/BRIEF.md
# Host Mailbox Command Sequencer with Pulsed SCI

This block sits on the device side of a byte-wide host mailbox that has a command port and a data port. Each host write lands in a one-byte input buffer and raises the input-full flag. The device consumes the byte on the next clock. A small command engine walks each multi-byte command, serves reads and writes from an internal register file, answers event queries and tracks a burst-mode flag. Bytes going back to the host pass through a one-byte output buffer that has its own full flag.

The interrupt to the host is a one-clock pulse rather than a level. Its line is owned by this block alone and the host treats it as an edge event. Each command type has its own fixed schedule of pulses: some protocol steps raise one and others deliberately stay quiet. A bank of event-request inputs records pending events. The first pending event raises an event flag with a pulse. The host then issues a query, which returns the lowest pending event number.

The host reads the status register on the command port and the output buffer on the data port. The read data output always shows the port currently selected. A read strobe on the data port empties the output buffer.

Top module: `sci_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, the output-buffer-full flag is clear, and the interrupt line stays low while no stimulus is applied.
- R2: A host write sets the input-full flag (status bit 1) at the next clock edge. It also sets the command flag (status bit 3) to 1 for a command-port write and to 0 for a data-port write. The input-full flag clears one clock later unless another write arrives.
- R3: Command 0x81 (write) takes a command byte, an address byte and a data byte. Each of the three bytes produces exactly one interrupt pulse when it is consumed. The data byte is stored at the given address.
- R4: Command 0x80 (read) produces one pulse when the command byte is consumed and none for the address byte. It then sets the output-buffer-full flag (status bit 0) with the stored byte and pulses once. A data-port read strobe clears that flag.
- R5: Command 0x84 (query) produces exactly one pulse in total, at the moment the output buffer fills. The byte returned is the lowest pending event index counted from 1, or 0 when nothing is pending, and that event is cleared.
- R6: Command 0x82 (burst on) sets the burst flag (status bit 4) and places 0x90 in the output buffer with one pulse. Command 0x83 (burst off) clears the burst flag with one pulse.
- R7: The event flag (status bit 5) sets, with one pulse, whenever it is clear and any event is pending. Query acceptance clears it. If events are still pending afterwards, it sets again with a fresh pulse.
- R8: A command-port write arriving in the middle of a command abandons that command. The new byte is decoded as a fresh command, and the abandoned sequence has no further effect.
- R9: Every pulse is exactly one clock wide, and two pulses always have at least one low cycle between them. Requests that coincide are delayed, not dropped.
- R10: A data-port byte with no command in progress, and a command byte with an unknown opcode, are consumed without a pulse and change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; on the data port it empties the output buffer |
| host_cmd_sel | input | 1 | 1 selects the command/status port, 0 the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte or output buffer, following host_cmd_sel |
| evt_req | input | NEV | One bit per device event; a high bit marks that event pending |
| sci_pulse | output | 1 | One-clock interrupt pulse to the host |

## Verification
A wrong step register shows up at the port as a missing or extra pulse within two cycles of the byte that was consumed, or as a wrong byte in the output buffer. A lost pending-event bit or a stuck event flag changes the next query result or the status byte immediately. A miscounted pulse backlog appears as two adjacent high cycles or as one pulse too few in the window after a collision. The bench counts pulses in a fixed window after every byte and compares each returned byte against a queue of expected values.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ   = 8'h80;
  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h81;
  localparam logic [BYTE_W-1:0] OP_BST_ON = 8'h82;
  localparam logic [BYTE_W-1:0] OP_BST_OFF= 8'h83;
  localparam logic [BYTE_W-1:0] OP_QUERY  = 8'h84;
  localparam logic [BYTE_W-1:0] BST_ACK   = 8'h90;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_RD_RET,
    ST_WR_ADDR,
    ST_WR_DATA
  } step_e;
endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_evt_pick.sv
module mbx_evt_pick #(
  parameter int NEV = 8,
  parameter int OW  = 8
) (
  input  logic [NEV-1:0] pend,
  output logic [NEV-1:0] pick_mask,
  output logic [OW-1:0]  pick_num
);
  always_comb begin
    pick_mask = '0;
    pick_num  = '0;
    for (int i = NEV - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick_mask    = '0;
        pick_mask[i] = 1'b1;
        pick_num     = OW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/mbx_sci_gen.sv
module mbx_sci_gen #(
  parameter int REQ_W = 2,
  parameter int OWE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REQ_W-1:0] nreq,
  output logic             sci_pulse
);
  localparam int SUM_W = ((REQ_W > OWE_W) ? REQ_W : OWE_W) + 1;
  localparam logic [SUM_W-1:0] OWE_MAX = SUM_W'((1 << OWE_W) - 1);

  logic [OWE_W-1:0] owed_q;
  logic [SUM_W-1:0] total, rem;
  logic             fire;

  always_comb begin
    total = SUM_W'(owed_q) + SUM_W'(nreq);
    fire  = (total != '0) && !sci_pulse;
    rem   = total - SUM_W'(fire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q    <= '0;
      sci_pulse <= 1'b0;
    end else begin
      sci_pulse <= fire;
      owed_q    <= (rem > OWE_MAX) ? OWE_MAX[OWE_W-1:0] : rem[OWE_W-1:0];
    end
  end
endmodule

// File: rtl/sci_mailbox.sv
module sci_mailbox
  import mbx_pkg::*;
#(
  parameter int AW  = 8,
  parameter int NEV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_cmd_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic [NEV-1:0]    evt_req,
  output logic              sci_pulse
);
  step_e             st_q, st_d;
  logic              ibf_q, ib_cmd_q, obf_q, obf_d, burst_q, burst_d, sci_evt_q, sci_evt_d;
  logic [BYTE_W-1:0] ib_data_q, odata_q, odata_d;
  logic [AW-1:0]     waddr_q, waddr_d;
  logic [NEV-1:0]    pend_q, pend_d, clr_mask, pick_mask;
  logic [BYTE_W-1:0] pick_num, rf_q;
  logic              rf_we, qr_accept, req_step, req_ret, req_evt;
  logic [1:0]        nreq;

  mbx_regfile #(.AW(AW), .DW(BYTE_W)) rf_i (
    .clk(clk), .we(rf_we), .waddr(waddr_q), .wdata(ib_data_q),
    .raddr(ib_data_q[AW-1:0]), .rdata(rf_q)
  );

  mbx_evt_pick #(.NEV(NEV), .OW(BYTE_W)) pick_i (
    .pend(pend_q), .pick_mask(pick_mask), .pick_num(pick_num)
  );

  always_comb begin
    st_d      = st_q;
    obf_d     = obf_q;
    odata_d   = odata_q;
    burst_d   = burst_q;
    waddr_d   = waddr_q;
    rf_we     = 1'b0;
    clr_mask  = '0;
    qr_accept = 1'b0;
    req_step  = 1'b0;
    req_ret   = 1'b0;
    req_evt   = 1'b0;

    if (host_rd && !host_cmd_sel) obf_d = 1'b0;

    if (st_q == ST_RD_RET) begin
      obf_d   = 1'b1;
      odata_d = rf_q;
      req_ret = 1'b1;
      st_d    = ST_IDLE;
    end

    if (ibf_q) begin
      if (ib_cmd_q) begin
        st_d = ST_IDLE;
        case (ib_data_q)
          OP_READ:  begin st_d = ST_RD_ADDR; req_step = 1'b1; end
          OP_WRITE: begin st_d = ST_WR_ADDR; req_step = 1'b1; end
          OP_BST_ON: begin
            burst_d  = 1'b1;
            obf_d    = 1'b1;
            odata_d  = BST_ACK;
            req_step = 1'b1;
          end
          OP_BST_OFF: begin burst_d = 1'b0; req_step = 1'b1; end
          OP_QUERY: begin
            qr_accept = 1'b1;
            clr_mask  = pick_mask;
            obf_d     = 1'b1;
            odata_d   = pick_num;
            req_step  = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (st_q)
          ST_RD_ADDR: st_d = ST_RD_RET;
          ST_WR_ADDR: begin
            waddr_d  = ib_data_q[AW-1:0];
            st_d     = ST_WR_DATA;
            req_step = 1'b1;
          end
          ST_WR_DATA: begin
            rf_we    = 1'b1;
            st_d     = ST_IDLE;
            req_step = 1'b1;
          end
          default: ;
        endcase
      end
    end

    pend_d    = (pend_q & ~clr_mask) | evt_req;
    sci_evt_d = sci_evt_q;
    if (qr_accept) begin
      sci_evt_d = 1'b0;
    end else if (!sci_evt_q && (pend_d != '0)) begin
      sci_evt_d = 1'b1;
      req_evt   = 1'b1;
    end

    nreq = 2'(req_step) + 2'(req_ret) + 2'(req_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ibf_q     <= 1'b0;
      ib_cmd_q  <= 1'b0;
      ib_data_q <= '0;
      obf_q     <= 1'b0;
      odata_q   <= '0;
      burst_q   <= 1'b0;
      sci_evt_q <= 1'b0;
      pend_q    <= '0;
      waddr_q   <= '0;
    end else begin
      st_q      <= st_d;
      obf_q     <= obf_d;
      odata_q   <= odata_d;
      burst_q   <= burst_d;
      sci_evt_q <= sci_evt_d;
      pend_q    <= pend_d;
      waddr_q   <= waddr_d;
      if (host_wr) begin
        ibf_q     <= 1'b1;
        ib_cmd_q  <= host_cmd_sel;
        ib_data_q <= host_wdata;
      end else if (ibf_q) begin
        ibf_q <= 1'b0;
      end
    end
  end

  mbx_sci_gen #(.REQ_W(2), .OWE_W(2)) sci_i (
    .clk(clk), .rst(rst), .nreq(nreq), .sci_pulse(sci_pulse)
  );

  assign host_rdata = host_cmd_sel
                    ? {2'b00, sci_evt_q, burst_q, ib_cmd_q, 1'b0, ibf_q, obf_q}
                    : odata_q;
endmodule

// File: rtl/sci_mailbox_chk.sv
module sci_mailbox_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic          sci_pulse,
  input logic          ibf,
  input logic          obf,
  input logic          burst,
  input logic [DW-1:0] odata
);
  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
    sci_pulse |=> !sci_pulse); // R9

  AST_WR_FILLS_IBF: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> ibf); // R2

  AST_IBF_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (ibf && !host_wr) |=> !ibf); // R2

  AST_BURST_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(burst) |-> (obf && odata == DW'(8'h90))); // R6
endmodule

bind sci_mailbox sci_mailbox_chk #(.DW(8)) chk_i (
  .clk(clk), .rst(rst), .host_wr(host_wr), .sci_pulse(sci_pulse),
  .ibf(ibf_q), .obf(obf_q), .burst(burst_q), .odata(odata_q)
);

// File: tb/sci_mailbox_tb_top.sv
`timescale 1ns/1ps
module sci_mailbox_tb_top;
  localparam int NEV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_cmd_sel = 1'b1;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [NEV-1:0] evt_req = '0;
  logic       sci_pulse;

  int n_cmp = 0, n_bad = 0, n_pulse = 0;
  logic prev_pulse = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  sci_mailbox #(.AW(8), .NEV(NEV)) dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_cmd_sel(host_cmd_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .evt_req(evt_req), .sci_pulse(sci_pulse)
  );

  // monitor: counts pulses, checks spacing
  always @(negedge clk) begin
    if (!rst) begin
      if (sci_pulse) n_pulse++;
      if (sci_pulse && prev_pulse) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: adjacent pulses, actual 1 expected 0");
      end
      prev_pulse = sci_pulse;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic status(input string req, input logic [7:0] exp, input logic [7:0] mask);
    host_cmd_sel = 1'b1;
    #0.5;
    check(req, int'(host_rdata & mask), int'(exp & mask));
  endtask

  // driver: one byte, then count pulses in a window
  task automatic step(input logic sel, input logic [7:0] b, input int exp_p,
                      input string req);
    int p0;
    @(negedge clk);
    host_cmd_sel = sel; host_wdata = b; host_wr = 1'b1;
    p0 = n_pulse;
    @(negedge clk);
    host_wr = 1'b0;
    repeat (5) @(negedge clk);
    check(req, n_pulse - p0, exp_p);
  endtask

  // scoreboard pop on host data read
  task automatic rd_data(input string req);
    logic [7:0] e;
    @(negedge clk);
    host_cmd_sel = 1'b0;
    #0.5;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    check(req, int'(host_rdata), int'(e));
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    status(req, 8'h00, 8'h01);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    begin
      int p0 = n_pulse;
      repeat (4) @(negedge clk);
      check("R1 quiet", n_pulse - p0, 0);
    end
    status("R1 reset status", 8'h00, 8'hFF);

    // R2: flags after a command-port write
    @(negedge clk);
    host_cmd_sel = 1'b1; host_wdata = 8'h55; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    status("R2 ibf+cmd", 8'h0A, 8'hFF);
    @(negedge clk);
    status("R2 ibf drained", 8'h08, 8'hFF);
    // R10: unknown opcode above gave no pulse
    step(1'b1, 8'h7E, 0, "R10 unknown opcode");
    // R2: data-port write clears cmd flag
    @(negedge clk);
    host_cmd_sel = 1'b0; host_wdata = 8'h11; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    status("R2 data port flags", 8'h02, 8'hFF);
    repeat (3) @(negedge clk);

    // R3: write 0x55 to 0x10, 0xA5 to 0x20
    step(1'b1, 8'h81, 1, "R3 cmd");
    step(1'b0, 8'h10, 1, "R3 addr");
    step(1'b0, 8'h55, 1, "R3 data");
    step(1'b1, 8'h81, 1, "R3 cmd b");
    step(1'b0, 8'h20, 1, "R3 addr b");
    step(1'b0, 8'hA5, 1, "R3 data b");

    // R10: stray data byte in idle
    step(1'b0, 8'h77, 0, "R10 stray data");
    status("R10 no obf", 8'h00, 8'h37);

    // R4: read back 0x10
    step(1'b1, 8'h80, 1, "R4 cmd");
    step(1'b0, 8'h10, 1, "R4 addr+ret");
    exp_q.push_back(8'h55);
    status("R4 obf set", 8'h01, 8'h01);
    rd_data("R4 data/R10 memory");

    // R8: abort a write after its address
    step(1'b1, 8'h81, 1, "R8 cmd");
    step(1'b0, 8'h20, 1, "R8 addr");
    step(1'b1, 8'h80, 1, "R8 abort to read");
    step(1'b0, 8'h20, 1, "R8 read ret");
    exp_q.push_back(8'hA5);
    rd_data("R8 old content");

    // R6: burst on/off
    step(1'b1, 8'h82, 1, "R6 burst on");
    exp_q.push_back(8'h90);
    status("R6 burst flag", 8'h11, 8'h31);
    rd_data("R6 ack byte");
    step(1'b1, 8'h83, 1, "R6 burst off");
    status("R6 burst clear", 8'h00, 8'h10);

    // R7: events 3 and 5 together
    begin
      int p0;
      @(negedge clk);
      p0 = n_pulse;
      evt_req = 8'b0010_1000;
      @(negedge clk);
      evt_req = '0;
      repeat (3) @(negedge clk);
      check("R7 event pulse", n_pulse - p0, 1);
    end
    status("R7 event flag", 8'h20, 8'h37);
    // query: one pulse for result, one for re-arm
    step(1'b1, 8'h84, 2, "R7 query rearm");
    exp_q.push_back(8'h04);
    rd_data("R5 lowest index");
    status("R7 flag set again", 8'h20, 8'h20);
    step(1'b1, 8'h84, 1, "R5 query pulse");
    exp_q.push_back(8'h06);
    rd_data("R5 second index");
    status("R7 flag clear", 8'h00, 8'h20);
    step(1'b1, 8'h84, 1, "R5 empty query");
    exp_q.push_back(8'h00);
    rd_data("R5 zero");

    // R9: event arrives on the same edge as a burst-off pulse
    begin
      int p0;
      @(negedge clk);
      host_cmd_sel = 1'b1; host_wdata = 8'h83; host_wr = 1'b1;
      p0 = n_pulse;
      @(negedge clk);
      host_wr = 1'b0;
      evt_req = 8'h01;
      @(negedge clk);
      evt_req = '0;
      repeat (5) @(negedge clk);
      check("R9 collision deferred", n_pulse - p0, 2);
    end
    step(1'b1, 8'h84, 1, "R9 cleanup query");
    exp_q.push_back(8'h01);
    rd_data("R9 cleanup value");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule